// File: doc/BRIEF.md
# Linked-List Transmit Descriptor Walker

The block feeds a MAC transmit path from frames that software has queued in memory. Each frame is described by a 16-byte descriptor. Each descriptor carries an ownership flag, a buffer pointer, a length and the address of the next descriptor, so the queue is a linked list and not a fixed ring. Software loads the address of the first descriptor while the engine is stopped. It enables transmission and writes a poll demand. The engine then reads descriptors through a single-outstanding memory master and streams each buffer out as bytes on a valid/ready interface. After the last byte of a frame is accepted, it writes the status back and hands the descriptor back to the CPU.

The walk ends at the first descriptor that the CPU still owns. That descriptor stays as the current descriptor, and an unavailable cause is raised. A later poll demand re-reads the same entry, so software can append frames and poll again. Four sticky cause bits report completions, the stop condition and memory errors. Each is cleared by writing a one to it.

Top module: `txdesc_walker`

## Requirements
- R1: During and straight after reset, `mem_req` and `tx_valid` are low, `cause` is 0 and `cur_desc` is 0.
- R2: A walk begins only when `tx_enable` is high and a `poll_demand` pulse has been recorded. A pulse that arrives while `tx_enable` is low is kept, and the walk starts once `tx_enable` rises.
- R3: A descriptor is four 32-bit little-endian words at byte offsets 0 (flags), 4 (buffer byte address), 8 (status; frame length in bits 15:0) and 12 (next descriptor address). Flags bit 31 set means the device owns the descriptor, and flags bit 2 enables the per-frame interrupt marker.
- R4: The bytes of a frame leave in ascending address order from any byte-aligned buffer address. `tx_last` marks only the final byte. Data and `tx_last` stay stable while stalled. A zero-length frame emits no bytes.
- R5: Only after the last byte is accepted, the engine writes the status word as the original value with bit 19 set, and with bit 16 set only when flags bit 2 is set. It then writes the flags with bit 31 cleared and the other bits kept, and moves on to the next-descriptor address.
- R6: Each completed frame sets `cause[0]` (frame complete) and `cause[1]` (frame interrupt). `cause[2]` means a descriptor was unavailable and `cause[3]` means a memory error occurred.
- R7: When the engine reads a flags word with bit 31 clear, it stops, sets `cause[2]` and leaves `cur_desc` on that descriptor. The next poll demand reads that same descriptor again, as one flags read.
- R8: If `tx_enable` falls during a frame, that frame completes and the engine halts before reading the next descriptor, with `cur_desc` pointing at it.
- R9: A memory response with `mem_err` set sets `cause[3]` and halts the engine with no write-back. Poll demands are ignored until `base_load` is pulsed.
- R10: `base_load` copies `list_base` into `cur_desc` only while the engine is idle or halted. While a walk is running it has no effect.
- R11: Each `cause_clr` bit clears its cause bit. A cause set in the same cycle as its clear stays set.
- R12: Once `mem_req` is raised, it stays high with address, direction and write data unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable | input | 1 | Transmit enable control bit |
| poll_demand | input | 1 | One-cycle poll demand pulse |
| base_load | input | 1 | Load `list_base` into the current descriptor pointer |
| list_base | input | 32 | Address of the first descriptor |
| cause_clr | input | 4 | Write-one-to-clear for the cause bits |
| cause | output | 4 | Sticky causes: 0 complete, 1 frame interrupt, 2 unavailable, 3 memory error |
| cur_desc | output | 32 | Address of the current descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Error response, qualified by `mem_ack` |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
Two events can land in the same cycle. Software can clear the cause bits in the very cycle that the acknowledged ownership write-back sets the completion causes. The memory model in the bench provokes this. It drives `cause_clr` to all ones in the same cycle that it acknowledges the flags write of a chosen descriptor. On the next cycle the bench expects both completion bits still set and the other bits cleared. The sweeps walk chains of descriptors that cover every length from 0 to 8, every buffer byte offset and both interrupt-enable settings, under continuous and irregular `tx_ready`.

// File: rtl/txdesc_walker.sv
module txdesc_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_enable,
  input  logic        poll_demand,
  input  logic        base_load,
  input  logic [31:0] list_base,
  input  logic [3:0]  cause_clr,
  output logic [3:0]  cause,
  output logic [31:0] cur_desc,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  output logic        tx_last,
  input  logic        tx_ready
);
  localparam int OWN_BIT  = 31;
  localparam int IEN_BIT  = 2;
  localparam int DONE_BIT = 19;
  localparam int FINT_BIT = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_FLAGS, S_BUF, S_LEN, S_NEXT, S_FETCH, S_SEND, S_WSTAT, S_WFLAGS, S_HALT
  } st_t;

  st_t         st;
  logic [31:0] desc_q, flags_q, bufp_q, stat_q, next_q, word_q;
  logic [15:0] left_q;
  logic [3:0]  cause_q, cause_set;
  logic        pend_q;
  logic        bus_done, bus_ok, bus_bad, start;

  assign mem_req  = (st == S_FLAGS) || (st == S_BUF) || (st == S_LEN) || (st == S_NEXT) ||
                    (st == S_FETCH) || (st == S_WSTAT) || (st == S_WFLAGS);
  assign mem_we   = (st == S_WSTAT) || (st == S_WFLAGS);
  assign bus_done = mem_req && mem_ack;
  assign bus_ok   = bus_done && !mem_err;
  assign bus_bad  = bus_done && mem_err;
  assign start    = (st == S_IDLE) && pend_q && tx_enable && !base_load;

  always_comb begin
    case (st)
      S_FLAGS, S_WFLAGS: mem_addr = desc_q;
      S_BUF:             mem_addr = desc_q + 32'd4;
      S_LEN, S_WSTAT:    mem_addr = desc_q + 32'd8;
      S_NEXT:            mem_addr = desc_q + 32'd12;
      S_FETCH:           mem_addr = {bufp_q[31:2], 2'b00};
      default:           mem_addr = '0;
    endcase
  end

  assign mem_wdata = (st == S_WSTAT)
                   ? (stat_q | (32'd1 << DONE_BIT) | ({31'd0, flags_q[IEN_BIT]} << FINT_BIT))
                   : (flags_q & ~(32'd1 << OWN_BIT));

  assign tx_valid = (st == S_SEND);
  assign tx_data  = word_q[{bufp_q[1:0], 3'b000} +: 8];
  assign tx_last  = (left_q == 16'd1);
  assign cur_desc = desc_q;
  assign cause    = cause_q;

  always_comb begin
    cause_set = '0;
    if (bus_bad) cause_set[3] = 1'b1;
    if (bus_ok && st == S_FLAGS && !mem_rdata[OWN_BIT]) cause_set[2] = 1'b1;
    if (bus_ok && st == S_WFLAGS) cause_set[1:0] = 2'b11;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      cause_q <= (cause_q & ~cause_clr) | cause_set;
      if (bus_bad)                          pend_q <= 1'b0;
      else if (poll_demand && st != S_HALT) pend_q <= 1'b1;
      else if (start)                       pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      desc_q  <= '0;
      flags_q <= '0;
      bufp_q  <= '0;
      stat_q  <= '0;
      next_q  <= '0;
      word_q  <= '0;
      left_q  <= '0;
    end else if (bus_bad) begin
      st <= S_HALT;
    end else begin
      case (st)
        S_IDLE: begin
          if (base_load)  desc_q <= list_base;
          else if (start) st <= S_FLAGS;
        end
        S_HALT: begin
          if (base_load) begin
            desc_q <= list_base;
            st     <= S_IDLE;
          end
        end
        S_FLAGS: if (bus_ok) begin
          flags_q <= mem_rdata;
          st      <= mem_rdata[OWN_BIT] ? S_BUF : S_IDLE;
        end
        S_BUF: if (bus_ok) begin
          bufp_q <= mem_rdata;
          st     <= S_LEN;
        end
        S_LEN: if (bus_ok) begin
          stat_q <= mem_rdata;
          left_q <= mem_rdata[15:0];
          st     <= S_NEXT;
        end
        S_NEXT: if (bus_ok) begin
          next_q <= mem_rdata;
          st     <= (left_q == 16'd0) ? S_WSTAT : S_FETCH;
        end
        S_FETCH: if (bus_ok) begin
          word_q <= mem_rdata;
          st     <= S_SEND;
        end
        S_SEND: if (tx_ready) begin
          bufp_q <= bufp_q + 32'd1;
          left_q <= left_q - 16'd1;
          if (left_q == 16'd1)          st <= S_WSTAT;
          else if (bufp_q[1:0] == 2'd3) st <= S_FETCH;
        end
        S_WSTAT: if (bus_ok) st <= S_WFLAGS;
        S_WFLAGS: if (bus_ok) begin
          desc_q <= next_q;
          st     <= tx_enable ? S_FLAGS : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txdesc_walker_checks.sv
module txdesc_walker_checks (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  cause,
  input logic [3:0]  cause_clr,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        mem_err,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        tx_last,
  input logic [7:0]  tx_data
);
  assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_byte_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && mem_req));

  assert_err_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=> (cause[3] && !mem_req && !tx_valid));

  assert_cause_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cause[0] && !cause_clr[0]) |=> cause[0]);

  assert_unavail_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cause[2] && !cause_clr[2]) |=> cause[2]);
endmodule

bind txdesc_walker txdesc_walker_checks u_chk (.*);

// File: tb/txdesc_walker_bench.sv
module txdesc_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_enable = 1'b0, poll_demand = 1'b0, base_load = 1'b0;
  logic [31:0] list_base = '0;
  logic [3:0]  cause_clr = '0;
  logic [3:0]  cause;
  logic [31:0] cur_desc;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last;
  logic        tx_ready = 1'b0;

  txdesc_walker u_txdesc_walker (.*);

  always #10 clk = ~clk;

  logic [31:0] mem [0:1023];
  logic [7:0]  cap [0:2047];
  logic        capl [0:2047];
  int          ncap = 0, reads = 0, checks = 0, failures = 0, cyc = 0;
  logic [15:0] rdy_pat = 16'hFFFF;
  int          ridx = 0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  logic        clr_arm = 1'b0, clr_hit = 1'b0;
  logic [31:0] clr_addr = '0;
  logic [3:0]  coincide_val = '0;

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 13 + 5) & 255);
  endfunction

  function automatic int flen(input int k); return k % 9; endfunction
  function automatic int fbuf(input int k); return 32'h400 + 32 * k + (k % 4); endfunction
  function automatic logic [31:0] fflags(input int k);
    return 32'h8000_0000 | ((k % 2) ? 32'h4 : 32'h0) | ((k % 3 == 0) ? 32'h20 : 32'h0);
  endfunction

  // memory responder, byte sink and clear/set coincidence, all driven at the falling edge
  always @(negedge clk) begin
    if (clr_hit) begin
      coincide_val = cause;
      cause_clr    = 4'h0;
      clr_hit      = 1'b0;
    end
    tx_ready = rdy_pat[ridx % 16];
    ridx++;
    if (tx_valid && tx_ready) begin
      cap[ncap]  = tx_data;
      capl[ncap] = tx_last;
      ncap++;
    end
    if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      mem_err = err_en && (mem_addr == err_addr);
      if (mem_we) begin
        if (!mem_err) mem[mem_addr[11:2]] = mem_wdata;
        if (clr_arm && mem_addr == clr_addr) begin
          cause_clr = 4'hF;
          clr_arm   = 1'b0;
          clr_hit   = 1'b1;
        end
      end else begin
        mem_rdata = mem[mem_addr[11:2]];
        reads++;
      end
    end else begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic fill_buffers();
    for (int w = 0; w < 1024; w++)
      mem[w] = (w < 256) ? 32'd0
             : {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
  endtask

  task automatic build_chain(input int first, input int n, input int base_k);
    for (int j = 0; j < n; j++) begin
      int k = base_k + j;
      int d = 4 * (first + j);
      mem[d]     = fflags(k);
      mem[d + 1] = fbuf(k);
      mem[d + 2] = 32'h0A00_0000 | flen(k);
      mem[d + 3] = 16 * (first + j + 1);
    end
    for (int i = 0; i < 4; i++) mem[4 * (first + n) + i] = 32'd0;
  endtask

  task automatic verify_chain(input int first, input int n, input int base_k, input string req);
    int pos = 0;
    for (int j = 0; j < n; j++) begin
      int k = base_k + j;
      int d = 4 * (first + j);
      for (int b = 0; b < flen(k); b++) begin
        check(cap[pos] == pat(fbuf(k) + b), "R4", $sformatf("%s frame %0d byte %0d", req, k, b),
              cap[pos], pat(fbuf(k) + b));
        check(capl[pos] == (b == flen(k) - 1), "R4", $sformatf("%s last marker frame %0d", req, k),
              capl[pos], b == flen(k) - 1);
        pos++;
      end
      check(mem[d + 2] == (32'h0A08_0000 | ((k % 2) ? 32'h1_0000 : 0) | flen(k)), "R5",
            $sformatf("%s status word frame %0d", req, k), mem[d + 2],
            32'h0A08_0000 | ((k % 2) ? 32'h1_0000 : 0) | flen(k));
      check(mem[d] == (fflags(k) & 32'h7FFF_FFFF), "R5", $sformatf("%s flags word frame %0d", req, k),
            mem[d], fflags(k) & 32'h7FFF_FFFF);
    end
    check(ncap == pos, "R4", {req, " byte count"}, ncap, pos);
  endtask

  task automatic pulse_poll();
    @(negedge clk) poll_demand = 1'b1;
    @(negedge clk) poll_demand = 1'b0;
  endtask

  task automatic pulse_load(input logic [31:0] a);
    @(negedge clk) begin list_base = a; base_load = 1'b1; end
    @(negedge clk) base_load = 1'b0;
  endtask

  task automatic pulse_clr(input logic [3:0] m);
    @(negedge clk) cause_clr = m;
    @(negedge clk) cause_clr = 4'h0;
  endtask

  task automatic wait_cause(input int bitn, input string req);
    int t = 0;
    while (!cause[bitn] && t < 5000) begin @(negedge clk); t++; end
    check(cause[bitn], req, $sformatf("wait for cause bit %0d", bitn), cause, 32'd1 << bitn);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    fill_buffers();
    idle_cycles(4);
    check(!mem_req && !tx_valid, "R1", "reset request/valid", {mem_req, tx_valid}, 0);
    check(cause == 0, "R1", "reset cause", cause, 0);
    check(cur_desc == 0, "R1", "reset cur_desc", cur_desc, 0);
    rst_n = 1'b1;
    idle_cycles(2);
    check(!mem_req && cause == 0, "R1", "idle after reset", {mem_req, cause}, 0);

    // R3 R5 R6 R7: sweep of lengths, offsets and interrupt enables, continuous ready
    build_chain(0, 24, 0);
    pulse_load(32'd0);
    tx_enable = 1'b1;
    pulse_poll();
    wait_cause(2, "R7");
    idle_cycles(2);
    verify_chain(0, 24, 0, "R3 sweep-a");
    check(cur_desc == 16 * 24, "R7", "cur_desc at cpu-owned entry", cur_desc, 16 * 24);
    check(cause == 4'b0111, "R6", "causes after sweep-a", cause, 4'b0111);

    // second sweep with irregular ready
    pulse_clr(4'hF);
    build_chain(0, 24, 24);
    ncap = 0;
    rdy_pat = 16'b1010_0110_0011_1001;
    pulse_load(32'd0);
    pulse_poll();
    wait_cause(2, "R7");
    idle_cycles(2);
    verify_chain(0, 24, 24, "R4 sweep-b");
    check(cause == 4'b0111, "R6", "causes after sweep-b", cause, 4'b0111);

    // R7: re-poll reads the same cpu-owned descriptor once
    pulse_clr(4'hF);
    reads = 0;
    pulse_poll();
    idle_cycles(30);
    check(reads == 1, "R7", "single flags re-read", reads, 1);
    check(cause == 4'b0100 && cur_desc == 16 * 24, "R7", "stop again on same entry", cause, 4'b0100);

    // R11: clear in the same cycle as the completion set
    build_chain(24, 1, 48);
    pulse_clr(4'hF);
    ncap = 0;
    clr_addr = 16 * 24;
    clr_arm = 1'b1;
    pulse_poll();
    wait_cause(2, "R7");
    idle_cycles(2);
    verify_chain(24, 1, 48, "R5 appended");
    check(coincide_val == 4'b0011, "R11", "set wins over same-cycle clear", coincide_val, 4'b0011);
    check(cur_desc == 16 * 25, "R7", "advanced past appended entry", cur_desc, 16 * 25);
    pulse_clr(4'b0010);
    check(cause == 4'b0101, "R11", "partial write-one-to-clear", cause, 4'b0101);

    // R8 R10: enable dropped mid-frame, base load while busy
    pulse_clr(4'hF);
    rdy_pat = 16'h0000;
    build_chain(0, 3, 8);
    ncap = 0;
    pulse_load(32'd0);
    pulse_poll();
    begin
      int t = 0;
      while (!tx_valid && t < 200) begin @(negedge clk); t++; end
    end
    tx_enable = 1'b0;
    pulse_load(32'h200);
    rdy_pat = 16'hFFFF;
    idle_cycles(60);
    check(cur_desc == 16, "R8", "halt at next descriptor", cur_desc, 16);
    check(ncap == 8, "R8", "current frame finished", ncap, 8);
    check(cause == 4'b0011, "R8", "no unavailable cause", cause, 4'b0011);
    check(mem[4][31] == 1'b1, "R8", "next descriptor untouched", mem[4], fflags(9));
    check(cur_desc != 32'h200, "R10", "base load ignored while busy", cur_desc, 16);

    // R2: poll while disabled is held until enable
    reads = 0;
    pulse_poll();
    idle_cycles(40);
    check(reads == 0, "R2", "no access while disabled", reads, 0);
    tx_enable = 1'b1;
    wait_cause(2, "R2");
    idle_cycles(2);
    check(cur_desc == 48, "R2", "walk resumed on enable", cur_desc, 48);
    check(ncap == 9, "R2", "resumed frames sent", ncap, 9);

    // R9: memory error halts, polls ignored, base load recovers
    pulse_clr(4'hF);
    build_chain(0, 2, 1);
    ncap = 0;
    err_en = 1'b1;
    err_addr = fbuf(1) & 32'hFFFF_FFFC;
    pulse_load(32'd0);
    pulse_poll();
    wait_cause(3, "R9");
    idle_cycles(4);
    check(cause == 4'b1000, "R9", "only error cause", cause, 4'b1000);
    check(ncap == 0, "R9", "no bytes after error", ncap, 0);
    check(mem[0] == fflags(1), "R9", "no write-back after error", mem[0], fflags(1));
    reads = 0;
    pulse_poll();
    idle_cycles(30);
    check(reads == 0, "R9", "poll ignored while halted", reads, 0);
    err_en = 1'b0;
    pulse_load(32'd0);
    pulse_poll();
    wait_cause(2, "R9");
    idle_cycles(2);
    check(cur_desc == 32 && ncap == 3, "R9", "recovered after base load", cur_desc, 32);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule